// File: doc/BRIEF.md
# Clock-Gated Virtual Channel Buffer

This block is one virtual channel of a router port: a small first-in first-out store of flits with an occupancy counter, full and empty flags, and a gate controller. The controller enables the storage clock only in cycles when a flit is actually entering or leaving. A router instantiates one group of these buffers for each of its four directional ports. Flits arrive from the physical channel on a valid strobe. They leave when the arbiter grants the channel, and the oldest held flit is always presented at the output.

A four-state status machine drives both flags and the gate. The states are initial, empty, waiting and full. After reset it sits in the initial state until the first flit is accepted. Storage is not clocked while the buffer is empty and idle, or while it holds data waiting for a grant, including when it is full. The enable output is the signal that a glitch-free clock gate consumes. Inside the block it acts as a clock enable on every storage register.

Top module: `vc_gated_buffer`

## Requirements
- R1: After reset, count is 0, empty is 1, full is 0, gate_en is 0 and state is the initial code 0.
- R2: The state stays at initial (code 0) until the first accepted write, and a grant seen in that state changes nothing.
- R3: A write with full clear is accepted and raises count by one on the next clock edge.
- R4: A write while full is ignored: count stays at DEPTH and the held flits come out unchanged afterwards.
- R5: A grant with empty clear is accepted and lowers count by one on the next clock edge. A grant while empty is ignored.
- R6: full is 1 exactly when count equals DEPTH, and empty is 1 exactly when count is 0.
- R7: rd_flit shows the oldest held flit, so flits leave in the order they were accepted.
- R8: gate_en is 1 exactly in cycles with an accepted write or accepted read. It is 0 when the buffer is empty and idle, and 0 when it holds data and is idle.
- R9: Once the buffer has left the initial state, state shows 1 (empty) when count is 0, 3 (full) when count is DEPTH, and 2 (waiting) otherwise.
- R10: A grant to a full buffer raises gate_en in that same cycle and frees one slot.
- R11: A write and a grant in the same cycle on a partly filled buffer are both accepted, and count is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Flit offered by the physical channel |
| wr_flit | input | DATA_W | Offered flit |
| rd_grant | input | 1 | Arbiter grant, removes the head flit |
| rd_flit | output | DATA_W | Oldest held flit |
| full | output | 1 | Buffer holds DEPTH flits |
| empty | output | 1 | Buffer holds no flit |
| count | output | CNT_W | Number of held flits |
| state | output | 2 | Status code: 0 initial, 1 empty, 2 waiting, 3 full |
| gate_en | output | 1 | Storage clock enable for the gate cell |

## Verification
gate_en and rd_flit are combinational from the current inputs and registers. The bench therefore samples them a few nanoseconds after driving the inputs, in the same cycle. count, full, empty and state change on the clock edge after an accepted access. They are checked at the next falling edge, before new inputs are driven. A scoreboard queue holds every flit the bench expects to be accepted. On every cycle in which a grant should be accepted, rd_flit is compared with the head of that queue.

// File: rtl/vcgb_pkg.sv
package vcgb_pkg;
    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_EMPTY = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FULL  = 2'd3
    } vc_state_e;
endpackage

// File: rtl/vcgb_gate_ctrl.sv
module vcgb_gate_ctrl
    import vcgb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             rd_grant,
    input  logic [CNT_W-1:0] count_q,
    output logic             wr_acc,
    output logic             rd_acc,
    output logic             gate_en,
    output logic             full,
    output logic             empty,
    output vc_state_e        state_q
);
    vc_state_e state_d;
    logic near_full, near_empty;

    always_comb begin
        near_full  = (count_q == CNT_W'(DEPTH - 1));
        near_empty = (count_q == CNT_W'(1));
        full    = (state_q == ST_FULL);
        empty   = (state_q == ST_INIT) || (state_q == ST_EMPTY);
        wr_acc  = wr_valid && !full;
        rd_acc  = rd_grant && !empty;
        gate_en = wr_acc || rd_acc;
        state_d = state_q;
        if (wr_acc && !rd_acc)
            state_d = near_full ? ST_FULL : ST_WAIT;
        else if (rd_acc && !wr_acc)
            state_d = near_empty ? ST_EMPTY : ST_WAIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    assert_full_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (count_q == CNT_W'(DEPTH)));
    assert_empty_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (count_q == '0));
    assert_init_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT && !wr_valid) |=> (state_q == ST_INIT));
    assert_gate_off_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> $stable(count_q));
endmodule

// File: rtl/vcgb_occupancy.sv
module vcgb_occupancy #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_en,
    input  logic             wr_acc,
    input  logic             rd_acc,
    output logic [CNT_W-1:0] count_q,
    output logic [PTR_W-1:0] wr_ptr_q,
    output logic [PTR_W-1:0] rd_ptr_q
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
    } occ_t;

    occ_t occ_d, occ_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        occ_d = occ_q;
        if (wr_acc) occ_d.wp = bump(occ_q.wp);
        if (rd_acc) occ_d.rp = bump(occ_q.rp);
        if (wr_acc && !rd_acc)      occ_d.cnt = occ_q.cnt + CNT_W'(1);
        else if (rd_acc && !wr_acc) occ_d.cnt = occ_q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       occ_q <= '0;
        else if (gate_en) occ_q <= occ_d;
    end

    assign count_q  = occ_q.cnt;
    assign wr_ptr_q = occ_q.wp;
    assign rd_ptr_q = occ_q.rp;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));
    assert_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !wr_acc) |=> (count_q == $past(count_q) - CNT_W'(1)));
    assert_both_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && wr_acc) |=> $stable(count_q));
endmodule

// File: rtl/vcgb_store.sv
module vcgb_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_en,
    input  logic              wr_acc,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_flit,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_flit
);
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (wr_acc && wr_ptr == PTR_W'(i)) mem_d[i] = wr_flit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (gate_en) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_flit = mem_q[rd_ptr];
endmodule

// File: rtl/vc_gated_buffer.sv
module vc_gated_buffer
    import vcgb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_flit,
    input  logic              rd_grant,
    output logic [DATA_W-1:0] rd_flit,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  count,
    output logic [1:0]        state,
    output logic              gate_en
);
    logic wr_acc, rd_acc;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    vc_state_e st;

    vcgb_gate_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_grant(rd_grant),
        .count_q(count), .wr_acc(wr_acc), .rd_acc(rd_acc), .gate_en(gate_en),
        .full(full), .empty(empty), .state_q(st)
    );

    vcgb_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .wr_acc(wr_acc),
        .rd_acc(rd_acc), .count_q(count), .wr_ptr_q(wr_ptr), .rd_ptr_q(rd_ptr)
    );

    vcgb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .wr_acc(wr_acc),
        .wr_ptr(wr_ptr), .wr_flit(wr_flit), .rd_ptr(rd_ptr), .rd_flit(rd_flit)
    );

    assign state = st;

    assert_full_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd_grant) |-> gate_en);
    assert_idle_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && !rd_grant) |-> !gate_en);
endmodule

// File: tb/vc_gated_buffer_test.sv
module vc_gated_buffer_test;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 4;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [DATA_W-1:0] wr_flit = '0;
    logic rd_grant = 1'b0;
    logic [DATA_W-1:0] rd_flit;
    logic full, empty, gate_en;
    logic [CNT_W-1:0] count;
    logic [1:0] state;

    int checks = 0;
    int errors = 0;
    int mcount = 0;
    int mstate = 0;
    logic [DATA_W-1:0] sb [$];

    always #10 clk = ~clk;

    vc_gated_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_flit(wr_flit),
        .rd_grant(rd_grant), .rd_flit(rd_flit), .full(full), .empty(empty),
        .count(count), .state(state), .gate_en(gate_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_regs();
        chk("R3/R5 count", int'(count), mcount);
        chk("R6 full", int'(full), int'(mcount == DEPTH));
        chk("R6 empty", int'(empty), int'(mcount == 0));
        chk("R9 state", int'(state), mstate);
    endtask

    // Driver and monitor for one cycle; registered outputs checked at the
    // falling edge, combinational ones 2 ns after driving.
    task automatic step(input logic wv, input logic [DATA_W-1:0] wd, input logic rg);
        bit wacc, racc;
        @(negedge clk);
        check_regs();
        wr_valid = wv; wr_flit = wd; rd_grant = rg;
        #2;
        wacc = wv && (mcount < DEPTH);
        racc = rg && (mcount > 0);
        chk("R8 gate_en", int'(gate_en), int'(wacc || racc));
        if (racc) begin
            chk("R7 rd_flit order", int'(rd_flit), int'(sb[0]));
            void'(sb.pop_front());
        end
        if (wacc) sb.push_back(wd);
        mcount = mcount + int'(wacc) - int'(racc);
        if (wacc || racc)
            mstate = (mcount == 0) ? 1 : (mcount == DEPTH) ? 3 : 2;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #35 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", int'(count), 0);
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 state", int'(state), 0);
        chk("R1 gate_en", int'(gate_en), 0);
        // R2 grants and idle in initial state are ignored
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b0);
        step(1'b0, '0, 1'b1);
        chk("R2 still initial", int'(state), 0);
        // R3 fill to full
        step(1'b1, 16'h1111, 1'b0);
        step(1'b1, 16'h2222, 1'b0);
        step(1'b1, 16'h3333, 1'b0);
        step(1'b1, 16'h4444, 1'b0);
        // R4 write when full ignored; R8 idle full gate off
        step(1'b1, 16'hDEAD, 1'b0);
        step(1'b0, '0, 1'b0);
        // R10 read of full buffer
        step(1'b0, '0, 1'b1);
        // R11 simultaneous write and read
        step(1'b1, 16'h5555, 1'b1);
        step(1'b1, 16'h6666, 1'b1);
        // R8 idle with waiting data
        step(1'b0, '0, 1'b0);
        // R5 drain, then grant on empty is ignored
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b0);
        // write into empty (not initial) buffer and simultaneous access at depth 1
        step(1'b1, 16'h7777, 1'b1);
        step(1'b1, 16'h8888, 1'b1);
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b0);
        chk("R5 queue drained", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule